// File: doc/BRIEF.md
# FP64 to INT64 Converter

This block turns one IEEE-754 binary64 floating-point operand into a signed 64-bit two's-complement integer. A new operand and a 2-bit rounding selector are taken on every clock. The converted integer and two status flags appear on registered outputs one clock later. The flags are `invalid` (the value has no 64-bit signed form) and `inexact` (fraction bits were discarded). Lane handling, masking, trap delivery and flag accumulation belong to the surrounding datapath.

Inputs that cannot be represented are not clamped. They return a single sentinel pattern, the most negative 64-bit integer, and raise `invalid`. Because the sentinel is also the correct result for exactly −2^63, the two cases can only be told apart by the flag.

Internally, an unpack stage classifies the operand and forms the significand and unbiased exponent. An align-and-round stage either shifts the significand left (large magnitudes) or right (fractional magnitudes) and applies the selected rounding. A pack stage applies the range test, the sign and the flags. The output register holds the result.

Top module: `fp64_to_int64_cvt`

## Requirements
- R1: All three outputs are registered: a value driven on the inputs appears on the outputs after exactly one rising clock edge. While `rst_n` is low the outputs read zero.
- R2: Finite inputs whose value is an integer in [−2^63, 2^63−1] convert exactly, with neither flag set. This includes every magnitude from 2^52 up to 2^63−1024.
- R3: `rnd_mode` selects rounding for non-integral values. The encoding is 0 = nearest with ties to even, 1 = toward −∞, 2 = toward +∞, 3 = toward zero.
- R4: In mode 0, a value exactly halfway between two integers rounds to the even one. For example, 2.5 gives 2, 3.5 gives 4 and −0.5 gives 0.
- R5: `inexact` is 1 exactly when the result is valid and the operand had a nonzero fractional part. `invalid` and `inexact` are never 1 together.
- R6: A NaN (quiet or signalling) or an infinity of either sign gives 0x8000_0000_0000_0000 with `invalid` = 1 and `inexact` = 0.
- R7: A finite value whose rounded result lies outside [−2^63, 2^63−1] gives 0x8000_0000_0000_0000 with `invalid` = 1 and `inexact` = 0. Exactly +2^63 is such a value.
- R8: An input of exactly −2^63 gives 0x8000_0000_0000_0000 with both flags 0.
- R9: A nonzero subnormal input gives 0, +1 or −1, chosen by its sign and the rounding mode, with `inexact` = 1.
- R10: +0 and −0 give 0 with both flags 0.
- R11: A negative operand gives the two's complement of its rounded magnitude. Rounding toward −∞ or +∞ is applied to the signed value, not to the magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_in | input | 64 | binary64 operand (bit 63 sign, bits 62:52 exponent, bits 51:0 fraction) |
| rnd_mode | input | 2 | Rounding selector, encoding as in R3 |
| int_out | output | 64 | Converted signed integer or sentinel |
| invalid | output | 1 | Result not representable |
| inexact | output | 1 | Valid result discarded nonzero fraction bits |

## Verification
The hardest corners to reach are at the edge of the range: values a few units from ±2^63, where one exponent step separates an exact result, the legal −2^63 and the sentinel. Ties that must round to even are equally hard to reach. Random operands almost never land on these, so the stimulus names them directly. These directed operands include 2^63−1024, ±2^63, the value just below −2^63, 2^64, and half-integers on both sides of zero, each under all four rounding modes. A pseudo-random sweep then spreads exponents from far below one up past 2^66, with random signs and fractions. Every output is compared on every clock against a floating-point reference model in the bench.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_DOWN      = 2'd1,
        RM_UP        = 2'd2,
        RM_ZERO      = 2'd3
    } rnd_mode_e;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_SUBNORM = 2'd1,
        CLS_NORMAL  = 2'd2,
        CLS_SPECIAL = 2'd3
    } fp_class_e;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int FP_W = 1 + EXP_W + MAN_W,
    localparam int E_W  = EXP_W + 1,
    localparam int BIAS = (1 << (EXP_W - 1)) - 1
) (
    input  logic [FP_W-1:0]       fp,
    output logic                  sign,
    output fp_class_e             cls,
    output logic [MAN_W:0]        sig,
    output logic signed [E_W-1:0] e_unb
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        sign  = fp[FP_W-1];
        exp_f = fp[FP_W-2:MAN_W];
        man_f = fp[MAN_W-1:0];
        sig   = {(exp_f != '0), man_f};
        if (exp_f == '0) begin
            cls   = (man_f == '0) ? CLS_ZERO : CLS_SUBNORM;
            e_unb = E_W'(1 - BIAS);
        end else begin
            cls   = (exp_f == '1) ? CLS_SPECIAL : CLS_NORMAL;
            e_unb = E_W'(int'(exp_f) - BIAS);
        end
    end
endmodule

// File: rtl/f2i_align_round.sv
module f2i_align_round
    import f2i_pkg::*;
#(
    parameter int MAN_W = 52,
    parameter int E_W   = 12,
    parameter int INT_W = 64,
    localparam int SIG_W = MAN_W + 1,
    localparam int EXT_W = SIG_W + INT_W
) (
    input  logic [SIG_W-1:0]      sig,
    input  logic signed [E_W-1:0] e_unb,
    input  logic                  sign,
    input  rnd_mode_e             mode,
    output logic [INT_W-1:0]      mag,
    output logic                  too_big,
    output logic                  lost
);
    logic [EXT_W-1:0] ext;
    logic [SIG_W-1:0] ipart;
    logic [INT_W-1:0] frac;
    logic             rnd_bit;
    logic             stk_bit;
    logic             incr;
    int               exp_i;
    int               rsh;

    always_comb begin
        exp_i   = int'(e_unb);
        too_big = 1'b0;
        lost    = 1'b0;
        incr    = 1'b0;
        rsh     = 0;
        ext     = '0;
        ipart   = '0;
        frac    = '0;
        rnd_bit = 1'b0;
        stk_bit = 1'b0;
        mag     = '0;
        if (exp_i >= MAN_W) begin
            if (exp_i > INT_W - 1) begin
                too_big = 1'b1;
            end else begin
                mag = {{(INT_W-SIG_W){1'b0}}, sig} << (exp_i - MAN_W);
            end
        end else begin
            rsh     = (MAN_W - exp_i > INT_W) ? INT_W : (MAN_W - exp_i);
            ext     = {sig, {INT_W{1'b0}}} >> rsh;
            ipart   = ext[EXT_W-1:INT_W];
            frac    = ext[INT_W-1:0];
            rnd_bit = frac[INT_W-1];
            stk_bit = |frac[INT_W-2:0];
            lost    = rnd_bit | stk_bit;
            unique case (mode)
                RM_NEAR_EVEN: incr = rnd_bit & (stk_bit | ipart[0]);
                RM_DOWN:      incr = sign & lost;
                RM_UP:        incr = ~sign & lost;
                RM_ZERO:      incr = 1'b0;
            endcase
            mag = {{(INT_W-SIG_W){1'b0}}, ipart} + {{(INT_W-1){1'b0}}, incr};
        end
    end
endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
    import f2i_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  logic             sign,
    input  fp_class_e        cls,
    input  logic [INT_W-1:0] mag,
    input  logic             too_big,
    input  logic             lost,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    logic over;

    always_comb begin
        over    = (mag > INDEF) || ((mag == INDEF) && !sign);
        invalid = (cls == CLS_SPECIAL) || too_big || over;
        inexact = lost && !invalid;
        if (invalid)   result = INDEF;
        else if (sign) result = -mag;
        else           result = mag;
    end
endmodule

// File: rtl/fp64_to_int64_cvt.sv
module fp64_to_int64_cvt
    import f2i_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    parameter int INT_W = 64,
    localparam int FP_W = 1 + EXP_W + MAN_W,
    localparam int E_W  = EXP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FP_W-1:0]  fp_in,
    input  logic [1:0]       rnd_mode,
    output logic [INT_W-1:0] int_out,
    output logic             invalid,
    output logic             inexact
);
    logic                  u_sign;
    fp_class_e             u_cls;
    logic [MAN_W:0]        u_sig;
    logic signed [E_W-1:0] u_exp;
    logic [INT_W-1:0]      r_mag;
    logic                  r_big;
    logic                  r_lost;
    logic [INT_W-1:0]      p_res;
    logic                  p_inv;
    logic                  p_inx;
    rnd_mode_e             mode_q;

    always_comb mode_q = rnd_mode_e'(rnd_mode);

    f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
        .fp    (fp_in),
        .sign  (u_sign),
        .cls   (u_cls),
        .sig   (u_sig),
        .e_unb (u_exp)
    );

    f2i_align_round #(.MAN_W(MAN_W), .E_W(E_W), .INT_W(INT_W)) u_round (
        .sig     (u_sig),
        .e_unb   (u_exp),
        .sign    (u_sign),
        .mode    (mode_q),
        .mag     (r_mag),
        .too_big (r_big),
        .lost    (r_lost)
    );

    f2i_pack #(.INT_W(INT_W)) u_pack (
        .sign    (u_sign),
        .cls     (u_cls),
        .mag     (r_mag),
        .too_big (r_big),
        .lost    (r_lost),
        .result  (p_res),
        .invalid (p_inv),
        .inexact (p_inx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_out <= '0;
            invalid <= 1'b0;
            inexact <= 1'b0;
        end else begin
            int_out <= p_res;
            invalid <= p_inv;
            inexact <= p_inx;
        end
    end
endmodule

// File: rtl/f2i_checker.sv
module f2i_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] fp_in,
    input logic [1:0]  rnd_mode,
    input logic [63:0] int_out,
    input logic        invalid,
    input logic        inexact
);
    localparam logic [63:0] INDEF = 64'h8000_0000_0000_0000;

    logic [10:0] ex;
    assign ex = fp_in[62:52];

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid && inexact));

    assert_special_indef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex == 11'h7FF) |=> (invalid && !inexact && int_out == INDEF));

    assert_zero_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_in[62:0] == 63'd0) |=> (int_out == 64'd0 && !invalid && !inexact));

    assert_large_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex >= 11'd1075 && ex <= 11'd1085) |=> (!invalid && !inexact));

    assert_subnormal_small_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex == 11'd0 && fp_in[51:0] != 52'd0) |=>
        (inexact && (int_out == 64'd0 || int_out == 64'd1 || int_out == '1)));

    assert_min_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_in == 64'hC3E0_0000_0000_0000) |=> (int_out == INDEF && !invalid && !inexact));

    assert_trunc_small_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_mode == 2'd3 && ex < 11'd1023) |=> (int_out == 64'd0 && !invalid));
endmodule

bind fp64_to_int64_cvt f2i_checker u_f2i_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .fp_in    (fp_in),
    .rnd_mode (rnd_mode),
    .int_out  (int_out),
    .invalid  (invalid),
    .inexact  (inexact)
);

// File: tb/fp64_to_int64_cvt_bench.sv
module fp64_to_int64_cvt_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] fp_in = '0;
    logic [1:0]  rnd_mode = '0;
    logic [63:0] int_out;
    logic        invalid;
    logic        inexact;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fp64_to_int64_cvt u_fp64_to_int64_cvt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fp_in    (fp_in),
        .rnd_mode (rnd_mode),
        .int_out  (int_out),
        .invalid  (invalid),
        .inexact  (inexact)
    );

    // Behavioural reference built on real arithmetic
    task automatic ref_cvt(input logic [63:0] b, input logic [1:0] m,
                           output logic [63:0] r, output bit inv, output bit inx);
        real x, f, d, y;
        inv = 0; inx = 0; r = 64'h8000_0000_0000_0000;
        if (b[62:52] == 11'h7FF) begin
            inv = 1;
            return;
        end
        x = $bitstoreal(b);
        case (m)
            2'd0: begin
                f = $floor(x);
                d = x - f;
                if (d > 0.5) y = f + 1.0;
                else if (d < 0.5) y = f;
                else if ($floor(f / 2.0) * 2.0 == f) y = f;
                else y = f + 1.0;
            end
            2'd1: y = $floor(x);
            2'd2: y = $ceil(x);
            default: y = (x >= 0.0) ? $floor(x) : $ceil(x);
        endcase
        if (y >= 9223372036854775808.0 || y < -9223372036854775808.0) begin
            inv = 1;
            return;
        end
        r   = 64'(longint'(y));
        inx = (y != x);
    endtask

    task automatic apply(input logic [63:0] v, input logic [1:0] m, input string tag);
        logic [63:0] er;
        bit ei, ex;
        fp_in = v;
        rnd_mode = m;
        ref_cvt(v, m, er, ei, ex);
        @(negedge clk);
        n_checks++;
        if (int_out !== er || invalid !== ei || inexact !== ex) begin
            n_fail++;
            $display("FAIL %s in=%h mode=%0d actual %h inv=%b inx=%b expected %h inv=%b inx=%b",
                     tag, v, m, int_out, invalid, inexact, er, ei, ex);
        end
    endtask

    task automatic all_modes(input logic [63:0] v, input string tag);
        for (int m = 0; m < 4; m++) apply(v, 2'(m), tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] s;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero
        n_checks++;
        if (int_out !== 64'd0 || invalid !== 1'b0 || inexact !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset actual %h %b %b expected 0 0 0", int_out, invalid, inexact);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: one-cycle latency, back-to-back operands
        apply(64'h3FF0_0000_0000_0000, 2'd0, "R1");
        apply(64'h4330_0000_0000_0000, 2'd0, "R1");
        // R2: exact integers
        apply(64'h43D0_0000_0000_0000, 2'd0, "R2");
        apply(64'h43DF_FFFF_FFFF_FFFF, 2'd1, "R2");
        apply(64'hC3DF_FFFF_FFFF_FFFF, 2'd2, "R2");
        // R3: modes on fractional values
        all_modes(64'h4006_0000_0000_0000, "R3");
        all_modes(64'hC006_0000_0000_0000, "R3");
        all_modes(64'h3FF8_0000_0000_0000, "R3");
        // R4: ties to even
        apply(64'h4004_0000_0000_0000, 2'd0, "R4");
        apply(64'h400C_0000_0000_0000, 2'd0, "R4");
        apply(64'hBFE0_0000_0000_0000, 2'd0, "R4");
        apply(64'h3FE0_0000_0000_0000, 2'd0, "R4");
        apply(64'hC004_0000_0000_0000, 2'd0, "R4");
        // R5: inexact only on valid lossy results
        all_modes(64'h3FD3_3333_3333_3333, "R5");
        // R6: NaN and infinities
        all_modes(64'h7FF8_0000_0000_0000, "R6");
        apply(64'h7FF0_0000_0000_0001, 2'd0, "R6");
        apply(64'h7FF0_0000_0000_0000, 2'd1, "R6");
        apply(64'hFFF0_0000_0000_0000, 2'd2, "R6");
        // R7: out of range finite values
        all_modes(64'h43E0_0000_0000_0000, "R7");
        all_modes(64'hC3E0_0000_0000_0001, "R7");
        apply(64'h43F0_0000_0000_0000, 2'd3, "R7");
        // R8: exactly -2^63
        all_modes(64'hC3E0_0000_0000_0000, "R8");
        // R9: subnormals
        all_modes(64'h0000_0000_0000_0001, "R9");
        all_modes(64'h800F_FFFF_FFFF_FFFF, "R9");
        // R10: signed zeros
        all_modes(64'h0000_0000_0000_0000, "R10");
        all_modes(64'h8000_0000_0000_0000, "R10");
        // R11: negatives round on the signed value
        all_modes(64'hBFF8_0000_0000_0000, "R11");
        all_modes(64'hC0C3_8880_0000_0000, "R11");

        // R3: pseudo-random sweep across the exponent range
        s = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 1200; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 7);
            s = s ^ (s << 17);
            apply({s[63], 11'(990 + int'(s[58:52])), s[51:0]}, s[1:0], "R3");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule